// File: doc/BRIEF.md
# I2C Byte Command Sequencer

This block is an I2C bus master that works through one command at a time. A command names a 7-bit target, a direction, and either one byte to transmit or a number of bytes to receive. It can also ask that the bus be left open when the command finishes. The sequencer produces the START condition, the control byte, the data bytes, every acknowledge bit and the closing STOP on the SCL and SDA lines. The caller never sees an acknowledge bit. It sees only the received bytes and an error flag.

One device value is reserved as a bare-byte selector. A command that uses it puts a single data byte on the wire with no START and no control byte. Several commands can therefore build one bus transaction between them. A typical use is a write that sets a memory pointer and holds the bus, followed by bare data bytes, or followed by a read that begins with a repeated START. The SCL timing comes from a divider that can be programmed at run time.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command whose device field is not 0xFF sends a START, then the control byte {dev[6:0], rw}, where rw = 1 means read. A write command then sends exactly one data byte.
- R2: A command whose device field is 0xFF sends only its data byte and its acknowledge slot. It sends no START, no repeated START and no control byte, and it ignores the read flag.
- R3: When the hold flag is set, a command ends without STOP and leaves SCL low. When the flag is clear, a STOP follows the last byte.
- R4: A normal command that starts while the bus is held begins with a repeated START (SDA falls while SCL is high, with no STOP before it) instead of a fresh START.
- R5: Only bits [7:0] of the transmit value go on the bus. The upper bits have no effect.
- R6: A read command receives the number of bytes given by its length field, in bus order, and raises rx_strobe for one cycle with each byte. A length of 0 is taken as 1.
- R7: During a read, the master drives ACK (SDA low) after every byte except the last one, and drives NACK (SDA released) after the last one.
- R8: When the target does not acknowledge a control byte or a written byte, cmd_err is set, the rest of the command is dropped and a STOP is sent, even if the hold flag is set.
- R9: One SCL quarter-phase lasts cfg_qdiv+1 clock cycles, so every SCL high pulse inside a transfer lasts 2*(cfg_qdiv+1) cycles. SDA changes while SCL is high only for START, repeated START and STOP.
- R10: A command is accepted on a cycle where cmd_valid and cmd_ready are both high. cmd_ready then stays low until the command ends. The end is marked by a one-cycle cmd_done pulse, and cmd_err is valid during that pulse.
- R11: After reset, SCL and SDA are released (both 1), cmd_ready is 1, and cmd_done and rx_strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_qdiv | input | DIV_W | Quarter-phase length minus one, in clock cycles |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_dev | input | 8 | 7-bit target address; 0xFF selects bare-byte mode |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_len | input | CNT_W | Number of bytes to read (0 is taken as 1) |
| cmd_txval | input | TXV_W | Transmit value; only bits [7:0] are sent |
| cmd_hold | input | 1 | Leave the bus open with no STOP |
| rx_data | output | 8 | Received byte |
| rx_strobe | output | 1 | One-cycle strobe for each received byte |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| cmd_err | output | 1 | The target did not acknowledge during the last command |
| scl_o | output | 1 | SCL drive (0 = pull low, 1 = release) |
| sda_o | output | 1 | SDA drive (0 = pull low, 1 = release) |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that sda_i is the wired-AND of the sequencer's own SDA drive and the target's drive. They also assume that no target holds SCL low, and that cfg_qdiv changes only while no command is running. The bench models an open-drain target with a pointer and a small memory. It releases SDA or drives it only on falling SCL edges, and it never stretches the clock. The bench changes the divider only between commands, and it offers a new command only after the previous cmd_done. Random pointers, lengths, data and upper transmit bits vary within those limits.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam logic [7:0] BARE_DEV = 8'hFF;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_STOP   = 2'd2,
    OP_BIT    = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_COND = 3'd1,
    S_BITS = 3'd2,
    S_ACK  = 3'd3,
    S_STOP = 3'd4,
    S_END  = 3'd5
  } seq_state_e;

  // {scl, sda} levels for each quarter phase of a bus operation
  function automatic logic [1:0] op_levels(bus_op_e op, logic [1:0] ph, logic b);
    logic [1:0] lv;
    case (op)
      OP_START:  case (ph)
                   2'd0: lv = 2'b11;
                   2'd1: lv = 2'b10;
                   2'd2: lv = 2'b10;
                   default: lv = 2'b00;
                 endcase
      OP_RSTART: case (ph)
                   2'd0: lv = 2'b01;
                   2'd1: lv = 2'b11;
                   2'd2: lv = 2'b10;
                   default: lv = 2'b00;
                 endcase
      OP_STOP:   case (ph)
                   2'd0: lv = 2'b00;
                   2'd1: lv = 2'b10;
                   default: lv = 2'b11;
                 endcase
      default:   lv = {(ph == 2'd1) || (ph == 2'd2), b};
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/i2cs_tick.sv
module i2cs_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick); // R9

endmodule

// File: rtl/i2cs_phy.sv
module i2cs_phy
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    op_start,
  input  bus_op_e op,
  input  logic    op_bit,
  input  logic    sda_in,
  output logic    scl_o,
  output logic    sda_o,
  output logic    op_done,
  output logic    rx_bit
);
  logic       active;
  logic [1:0] ph;
  bus_op_e    op_q;
  logic       bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ph      <= 2'd0;
      op_q    <= OP_STOP;
      bit_q   <= 1'b1;
      scl_o   <= 1'b1;
      sda_o   <= 1'b1;
      op_done <= 1'b0;
      rx_bit  <= 1'b1;
    end else begin
      op_done <= 1'b0;
      if (op_start && !active) begin
        active <= 1'b1;
        ph     <= 2'd0;
        op_q   <= op;
        bit_q  <= op_bit;
      end else if (active && tick) begin
        {scl_o, sda_o} <= op_levels(op_q, ph, bit_q);
        if (ph == 2'd2) rx_bit <= sda_in;
        if (ph == 2'd3) begin
          active  <= 1'b0;
          op_done <= 1'b1;
        end
        ph <= ph + 2'd1;
      end
    end
  end

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> (op_q != OP_BIT)); // R9

  AST_ONE_OP: assert property (@(posedge clk) disable iff (rst)
    op_done |-> !active); // R10

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8,
  parameter int TXV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_qdiv,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_dev,
  input  logic             cmd_read,
  input  logic [CNT_W-1:0] cmd_len,
  input  logic [TXV_W-1:0] cmd_txval,
  input  logic             cmd_hold,
  output logic [7:0]       rx_data,
  output logic             rx_strobe,
  output logic             cmd_done,
  output logic             cmd_err,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       state;
  logic             pend, op_start, op_bit_r, phy_done, phy_rx, tick;
  bus_op_e          op_sel, nxt_op;
  logic             nxt_bit;
  logic [6:0]       cur_dev;
  logic             cur_raw, cur_rd, cur_hold, is_ctrl, bus_open, err_q;
  logic [7:0]       tx_byte, sh;
  logic [2:0]       bitn;
  logic [CNT_W-1:0] remain;
  logic             recv;
  logic             unused_tx_hi;

  assign unused_tx_hi = ^cmd_txval[TXV_W-1:8];
  assign recv         = cur_rd && !is_ctrl;
  assign cmd_ready    = (state == S_IDLE);

  i2cs_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .div(cfg_qdiv), .tick(tick)
  );

  i2cs_phy phy_i (
    .clk(clk), .rst(rst), .tick(tick), .op_start(op_start), .op(op_sel),
    .op_bit(op_bit_r), .sda_in(sda_i), .scl_o(scl_o), .sda_o(sda_o),
    .op_done(phy_done), .rx_bit(phy_rx)
  );

  always_comb begin
    nxt_op  = OP_BIT;
    nxt_bit = 1'b1;
    case (state)
      S_COND: nxt_op = bus_open ? OP_RSTART : OP_START;
      S_BITS: nxt_bit = recv ? 1'b1 : sh[7];
      S_ACK:  nxt_bit = recv ? (remain == ONE) : 1'b1;
      S_STOP: nxt_op = OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pend      <= 1'b0;
      op_start  <= 1'b0;
      op_sel    <= OP_STOP;
      op_bit_r  <= 1'b1;
      cur_dev   <= '0;
      cur_raw   <= 1'b0;
      cur_rd    <= 1'b0;
      cur_hold  <= 1'b0;
      is_ctrl   <= 1'b0;
      bus_open  <= 1'b0;
      err_q     <= 1'b0;
      tx_byte   <= '0;
      sh        <= '0;
      bitn      <= '0;
      remain    <= ONE;
      rx_data   <= '0;
      rx_strobe <= 1'b0;
      cmd_done  <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      op_start  <= 1'b0;
      rx_strobe <= 1'b0;
      cmd_done  <= 1'b0;
      if (state == S_IDLE) begin
        if (cmd_valid) begin
          cur_dev  <= cmd_dev[6:0];
          cur_raw  <= (cmd_dev == BARE_DEV);
          cur_rd   <= cmd_read && (cmd_dev != BARE_DEV);
          cur_hold <= cmd_hold;
          tx_byte  <= cmd_txval[7:0];
          remain   <= (cmd_len == '0) ? ONE : cmd_len;
          err_q    <= 1'b0;
          cmd_err  <= 1'b0;
          bitn     <= '0;
          if (cmd_dev == BARE_DEV) begin
            sh      <= cmd_txval[7:0];
            is_ctrl <= 1'b0;
            state   <= S_BITS;
          end else begin
            state <= S_COND;
          end
        end
      end else if (state == S_END) begin
        cmd_done <= 1'b1;
        cmd_err  <= err_q;
        state    <= S_IDLE;
      end else if (!pend) begin
        op_start <= 1'b1;
        op_sel   <= nxt_op;
        op_bit_r <= nxt_bit;
        pend     <= 1'b1;
      end else if (phy_done) begin
        pend <= 1'b0;
        case (state)
          S_COND: begin
            bus_open <= 1'b1;
            sh       <= {cur_dev, cur_rd};
            is_ctrl  <= 1'b1;
            bitn     <= '0;
            state    <= S_BITS;
          end
          S_BITS: begin
            sh   <= {sh[6:0], phy_rx};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) state <= S_ACK;
          end
          S_ACK: begin
            if (recv) begin
              rx_data   <= sh;
              rx_strobe <= 1'b1;
              bitn      <= '0;
              if (remain == ONE) begin
                state <= cur_hold ? S_END : S_STOP;
              end else begin
                remain <= remain - ONE;
                state  <= S_BITS;
              end
            end else if (phy_rx) begin
              err_q <= 1'b1;
              state <= S_STOP;
            end else if (is_ctrl) begin
              is_ctrl <= 1'b0;
              bitn    <= '0;
              if (!cur_rd) sh <= tx_byte;
              state <= S_BITS;
            end else begin
              state <= cur_hold ? S_END : S_STOP;
            end
          end
          S_STOP: begin
            bus_open <= 1'b0;
            state    <= S_END;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done); // R10

  AST_ERR_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && cmd_err) |-> !bus_open); // R8

  AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !cmd_err && cur_hold && !cur_raw) |-> bus_open); // R3

  AST_BARE_NO_COND: assert property (@(posedge clk) disable iff (rst)
    (op_start && cur_raw) |-> (op_sel == OP_BIT || op_sel == OP_STOP)); // R2

  AST_RX_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> (cur_rd && !cur_raw)); // R6

endmodule

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb_top;
  localparam int DIV_W = 16;
  localparam int CNT_W = 8;
  localparam int TXV_W = 16;
  localparam logic [7:0] DEV = 8'h57;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [DIV_W-1:0] cfg_qdiv = 16'd1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_dev = 8'h00;
  logic             cmd_read = 1'b0;
  logic [CNT_W-1:0] cmd_len = '0;
  logic [TXV_W-1:0] cmd_txval = '0;
  logic             cmd_hold = 1'b0;
  logic [7:0]       rx_data;
  logic             rx_strobe, cmd_done, cmd_err, scl_o, sda_o;
  logic             slv_sda = 1'b1;
  wire              sda_line = sda_o & slv_sda;
  wire              scl_line = scl_o;

  i2c_cmd_seq #(.DIV_W(DIV_W), .CNT_W(CNT_W), .TXV_W(TXV_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_qdiv(cfg_qdiv), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_dev(cmd_dev), .cmd_read(cmd_read),
    .cmd_len(cmd_len), .cmd_txval(cmd_txval), .cmd_hold(cmd_hold),
    .rx_data(rx_data), .rx_strobe(rx_strobe), .cmd_done(cmd_done),
    .cmd_err(cmd_err), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- target model (open-drain, pointer + memory) ----------
  bit   [7:0] smem [256];
  bit   [7:0] sr;
  int         sst = 0, bitn = 0, ptr = 0;
  bit         first = 0, srd = 0, rd_nack = 0, in_txn = 0, nack_data = 0;
  int         n_start = 0, n_rstart = 0, n_stop = 0, n_mack = 0, n_mnack = 0;
  logic       p_scl = 1'b1, p_sda = 1'b1;

  always @(scl_line or sda_line) begin
    if (rst !== 1'b0) begin
      sst = 0; in_txn = 0;
    end else if (scl_line === 1'b1 && p_scl === 1'b1 && sda_line !== p_sda) begin
      if (sda_line === 1'b0) begin
        if (in_txn) n_rstart++; else n_start++;
        in_txn = 1; sst = 1; bitn = 0; slv_sda = 1'b1;
      end else begin
        n_stop++; in_txn = 0; sst = 0; slv_sda = 1'b1;
      end
    end else if (scl_line === 1'b1 && p_scl === 1'b0) begin
      if (sst != 0) begin
        if ((sst == 1 || sst == 2) && bitn < 8) sr = {sr[6:0], sda_line};
        if (sst == 3 && bitn == 8) begin
          rd_nack = sda_line;
          if (sda_line) n_mnack++; else n_mack++;
        end
        bitn++;
      end
    end else if (scl_line === 1'b0 && p_scl === 1'b1) begin
      if (bitn == 8) begin
        if (sst == 1) begin
          if (sr[7:1] == DEV[6:0]) begin slv_sda = 1'b0; srd = sr[0]; end
          else begin slv_sda = 1'b1; sst = 5; end
        end else if (sst == 2) begin
          if (nack_data) slv_sda = 1'b1;
          else begin
            slv_sda = 1'b0;
            if (first) begin ptr = sr; first = 0; end
            else begin smem[ptr] = sr; ptr = (ptr + 1) % 256; end
          end
        end else if (sst == 3) slv_sda = 1'b1;
      end else if (bitn == 9) begin
        bitn = 0;
        if (sst == 1) begin
          if (srd) begin
            sst = 3; sr = smem[ptr]; ptr = (ptr + 1) % 256; slv_sda = sr[7];
          end else begin
            sst = 2; first = 1; slv_sda = 1'b1;
          end
        end else if (sst == 2) slv_sda = 1'b1;
        else if (sst == 3) begin
          if (rd_nack) begin sst = 5; slv_sda = 1'b1; end
          else begin sr = smem[ptr]; ptr = (ptr + 1) % 256; slv_sda = sr[7]; end
        end
      end else if (sst == 3 && bitn >= 1 && bitn <= 7) begin
        slv_sda = sr[7 - bitn];
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  // ---------------- SCL high-width monitor and rx capture ----------------
  int   cyc = 0, rise_cyc = 0, w_seen = 0, w_bad = 0, rx_n = 0;
  bit   rise_ok = 0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  bit [7:0] rx_buf [1024];

  function automatic int exp_width(input int d);
    return 2 * (d + 1);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst) rise_ok = 0;
    else begin
      if (scl_line && !m_scl) begin rise_cyc = cyc; rise_ok = 1; end
      if (scl_line && m_scl && sda_line && !m_sda) rise_ok = 0;
      if (!scl_line && m_scl && rise_ok) begin
        w_seen++;
        if (cyc - rise_cyc != exp_width(int'(cfg_qdiv))) w_bad++;
        rise_ok = 0;
      end
      if (rx_strobe && rx_n < 1024) begin rx_buf[rx_n] = rx_data; rx_n++; end
    end
    m_scl = scl_line;
    m_sda = sda_line;
  end

  // ---------------- command helpers -------------------------------------
  bit [7:0] exp_mem [256];

  task automatic run_cmd(input logic [7:0] dev, input bit rd, input int len,
                         input logic [TXV_W-1:0] tx, input bit hold, output bit err);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_dev = dev; cmd_read = rd; cmd_len = len[CNT_W-1:0];
    cmd_txval = tx; cmd_hold = hold; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R10", "ready after accept", cmd_ready, 0);
    while (!cmd_done) @(negedge clk);
    err = cmd_err;
    @(negedge clk);
    check(cmd_done == 1'b0, "R10", "done width", cmd_done, 0);
  endtask

  // pointer set + bare data bytes, last one closes with STOP
  task automatic write_seq(input int p, input int n, input bit [7:0] d [8],
                           input bit [7:0] hi);
    bit e;
    int s0, r0;
    s0 = n_start; r0 = n_rstart;
    run_cmd(DEV, 0, 0, {hi, p[7:0]}, 1, e);
    check(e == 0, "R1", "pointer write err", e, 0);
    for (int i = 0; i < n; i++) begin
      run_cmd(8'hFF, 1, 0, {hi, d[i]}, (i < n - 1), e);
      check(e == 0, "R2", "bare byte err", e, 0);
      exp_mem[(p + i) % 256] = d[i];
    end
    check(n_start - s0 == 1 && n_rstart == r0, "R2", "conditions in write",
          (n_start - s0) * 16 + (n_rstart - r0), 16);
  endtask

  task automatic read_seq(input int p, input int n);
    bit e;
    int b0, r0, a0, k0, st0, eff;
    eff = (n == 0) ? 1 : n;
    run_cmd(DEV, 0, 0, {8'h00, p[7:0]}, 1, e);
    r0 = n_rstart; b0 = rx_n; a0 = n_mack; k0 = n_mnack; st0 = n_stop;
    run_cmd(DEV, 1, n, 16'h0, 0, e);
    check(e == 0, "R1", "read err", e, 0);
    check(n_rstart - r0 == 1, "R4", "repeated start count", n_rstart - r0, 1);
    check(n_stop - st0 == 1, "R3", "stop after read", n_stop - st0, 1);
    check(rx_n - b0 == eff, "R6", "rx byte count", rx_n - b0, eff);
    for (int i = 0; i < eff && b0 + i < rx_n; i++)
      check(rx_buf[b0 + i] == exp_mem[(p + i) % 256], "R6", "rx byte",
            rx_buf[b0 + i], exp_mem[(p + i) % 256]);
    check(n_mack - a0 == eff - 1 && n_mnack - k0 == 1, "R7", "master ack/nack",
          (n_mack - a0) * 256 + (n_mnack - k0), (eff - 1) * 256 + 1);
  endtask

  function automatic bit [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 2));
  endfunction

  // ---------------- main sequence ---------------------------------------
  initial begin
    bit e;
    bit [7:0] d [8];
    int s0, b0;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(scl_o == 1 && sda_o == 1, "R11", "bus released", {scl_o, sda_o}, 3);
    check(cmd_ready == 1, "R11", "ready", cmd_ready, 1);
    check(cmd_done == 0 && rx_strobe == 0, "R11", "no pulses", {cmd_done, rx_strobe}, 0);

    // pointer write held open: no STOP, SCL low
    s0 = n_stop;
    run_cmd(DEV, 0, 0, 16'h0034, 1, e);
    check(n_stop == s0, "R3", "no stop when held", n_stop - s0, 0);
    check(scl_o == 0, "R3", "scl low when held", scl_o, 0);
    check(n_start == 1, "R1", "fresh start", n_start, 1);
    // bare byte with junk upper bits, then STOP
    run_cmd(8'hFF, 1, 0, 16'hAB34, 0, e);
    exp_mem[8'h34] = 8'h34;
    check(n_stop == s0 + 1, "R3", "stop by default", n_stop - s0, 1);
    check(scl_o == 1 && sda_o == 1, "R3", "bus idle after stop", {scl_o, sda_o}, 3);
    check(smem[8'h34] == 8'h34, "R5", "low byte stored", smem[8'h34], 8'h34);
    check(n_start == 1 && n_rstart == 0, "R2", "bare byte no start",
          n_start * 16 + n_rstart, 16);
    read_seq(8'h34, 1);

    // page of 32 bytes, then 0x20-byte read
    run_cmd(DEV, 0, 0, 16'h0040, 1, e);
    for (int i = 0; i < 32; i++) begin
      run_cmd(8'hFF, 0, 0, {8'h5A, pat(i)}, (i < 31), e);
      exp_mem[(64 + i) % 256] = pat(i);
    end
    read_seq(8'h40, 32);
    read_seq(8'h47, 0);   // length 0 reads one byte
    check(w_bad == 0 && w_seen > 0, "R9", "scl high width div1", w_bad, 0);

    // slower divider
    cfg_qdiv = 16'd3;
    read_seq(8'h50, 3);
    check(w_bad == 0 && w_seen > 0, "R9", "scl high width div3", w_bad, 0);
    cfg_qdiv = 16'd1;

    // wrong device, hold requested: error, forced STOP
    s0 = n_stop; b0 = rx_n;
    run_cmd(8'h50, 0, 0, 16'h0011, 1, e);
    check(e == 1, "R8", "err on address nack", e, 1);
    check(n_stop == s0 + 1, "R8", "forced stop", n_stop - s0, 1);
    check(scl_o == 1 && sda_o == 1, "R8", "bus idle after err", {scl_o, sda_o}, 3);
    run_cmd(8'h50, 1, 4, 16'h0, 0, e);
    check(e == 1 && rx_n == b0, "R8", "read aborted", rx_n - b0, 0);

    // data byte nacked while hold set
    nack_data = 1;
    s0 = n_stop;
    run_cmd(DEV, 0, 0, 16'h0022, 1, e);
    check(e == 1, "R8", "err on data nack", e, 1);
    check(n_stop == s0 + 1, "R8", "stop despite hold", n_stop - s0, 1);
    nack_data = 0;
    run_cmd(DEV, 0, 0, 16'h0022, 0, e);
    check(e == 0, "R8", "err clears on next command", e, 0);

    // random write / read-back
    for (int it = 0; it < 25; it++) begin
      int p, n;
      p = $urandom_range(0, 255);
      n = $urandom_range(1, 6);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      write_seq(p, n, d, 8'($urandom));
      read_seq(p, $urandom_range(1, n));
    end
    check(w_bad == 0, "R9", "scl high width random", w_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule